// File: doc/BRIEF.md
# Framebuffer Scanout Parameter Unit

This block sits between the display configuration registers and the pixel fetcher of a video output path. Software may rewrite the configuration at any time. The block samples it only when a frame-start strobe arrives, so every frame is scanned with one consistent set of parameters. From the packed size word and the mode bits it works out the scanout geometry: enable state, pixel format, horizontal and vertical resolution, row pitch in bytes, start address, and whether the frame is blanked to a border colour. All of these are held stable until the next frame.

During the frame the fetcher asks for one line at a time. For each request the block returns the start address of that line. The first line starts at the latched base address, and each following line starts one row pitch further on. A request after the last line of the frame is refused. A one-cycle flag marks any enabled frame whose resolution or pixel format differs from the frame before it, so a downstream scaler or display format stage knows it must reconfigure.

Top module: `scanout_param_unit`

## Requirements
- R1: The size word holds three fields: bits 9:0 are words-per-line minus one (W), bits 19:10 are lines-per-field minus one (L), and bits 29:20 are the modulo plus one (M). Row pitch is `stride_bytes = (W + M) * 4`, which equals (words + modulo) × 4.
- R2: The horizontal resolution depends on `pix_format`. Codes 0 (ARGB1555) and 1 (RGB565) give 2 × words. Code 2 (packed RGB888) gives (4 × words) / 3, rounded down. Code 3 (ARGB8888) gives words.
- R3: The vertical resolution is L+1, or 2 × (L+1) when `interlace` is 1.
- R4: `disp_en` is 1 only when both `disp_enable` and `video_out` are 1. In a disabled frame, `hres` and `vres` read 0 and no `line_vld` pulse is issued.
- R5: `blank` follows `blank_req`, and `border_color` takes the value of `border_reg`, both sampled at the frame start.
- R6: All outputs except `fmt_changed`, `line_vld` and `line_addr` change only in the cycle after a `frame_start` strobe. Register changes between strobes have no effect on them.
- R7: `fmt_changed` pulses for one cycle, together with the newly latched parameters, when the new frame is enabled and its `hres`, `vres` or pixel format differs from the values latched before. A change only in pitch, address or blanking does not raise it.
- R8: A line request accepted in cycle t gives `line_vld` = 1 in cycle t+1. The first accepted request after a frame start returns `start_addr`. Each later request returns the previous address plus `stride_bytes`, modulo 2^ADDR_W.
- R9: Line requests are ignored (no `line_vld`) once `vres` lines have been issued in the frame, and in a cycle where `frame_start` is also high.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame boundary strobe; latches the configuration |
| line_req | input | 1 | Fetcher request for the next line address |
| size_reg | input | 30 | Packed size word (W, L, M fields) |
| disp_enable | input | 1 | Display enable bit |
| pix_format | input | 2 | Pixel format code |
| video_out | input | 1 | Video output enable bit |
| interlace | input | 1 | Interlaced output (doubles vertical lines) |
| blank_req | input | 1 | Blank the frame to the border colour |
| border_reg | input | 32 | Border colour value |
| base_addr | input | ADDR_W | Framebuffer base address |
| disp_en | output | 1 | Latched output enable |
| color_fmt | output | 2 | Latched pixel format |
| hres | output | 12 | Latched horizontal pixels |
| vres | output | 12 | Latched vertical lines |
| stride_bytes | output | 13 | Latched row pitch in bytes |
| start_addr | output | ADDR_W | Latched frame start address |
| blank | output | 1 | Latched blanking selection |
| border_color | output | 32 | Latched border colour |
| fmt_changed | output | 1 | One-cycle geometry/format change flag |
| line_vld | output | 1 | Line address strobe |
| line_addr | output | ADDR_W | Start address of the issued line |

## Verification
The hardest case to reach is the end of a line walk. The walk has to wrap the address space and then run past the last line of an interlaced frame, where the doubled line count must cut off further requests. The bench puts the base address a few bytes below the top of the address space and picks a small interlaced frame. It then issues more requests than there are lines, so the wrap, the cut-off and the refused extra requests all fall inside one short walk. A request that coincides with a new frame strobe is driven on purpose. This shows that the strobe wins, and that the next request restarts at the new base.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

    localparam int WORD_FW   = 10;
    localparam int LINE_FW   = 10;
    localparam int MOD_FW    = 10;
    localparam int LINE_LSB  = WORD_FW;
    localparam int MOD_LSB   = LINE_LSB + LINE_FW;
    localparam int SIZE_W    = MOD_LSB + MOD_FW;
    localparam int HRES_W    = WORD_FW + 2;
    localparam int VRES_W    = LINE_FW + 2;
    localparam int SUM_W     = ((WORD_FW > MOD_FW) ? WORD_FW : MOD_FW) + 1;
    localparam int STRIDE_W  = SUM_W + 2;
    localparam int BORDER_W  = 32;

    typedef enum logic [1:0] {
        PIX_ARGB1555 = 2'd0,
        PIX_RGB565   = 2'd1,
        PIX_RGB888   = 2'd2,
        PIX_ARGB8888 = 2'd3
    } pix_fmt_e;

    typedef struct packed {
        logic                en;
        pix_fmt_e            fmt;
        logic [HRES_W-1:0]   hres;
        logic [VRES_W-1:0]   vres;
        logic [STRIDE_W-1:0] stride;
        logic                blank;
    } scan_geom_t;

    function automatic logic [HRES_W-1:0] pixels_per_line(
        input pix_fmt_e         f,
        input logic [WORD_FW:0] words
    );
        logic [HRES_W:0] quad;
        logic [HRES_W:0] third;
        quad  = {words, 2'b00};
        third = quad / 3;
        case (f)
            PIX_ARGB1555,
            PIX_RGB565:   return {words, 1'b0};
            PIX_RGB888:   return third[HRES_W-1:0];
            default:      return {1'b0, words};
        endcase
    endfunction

    function automatic logic [VRES_W-1:0] field_lines(
        input logic [LINE_FW:0] lines,
        input logic             ilace
    );
        return ilace ? {lines, 1'b0} : {1'b0, lines};
    endfunction

endpackage

// File: rtl/scanout_decode.sv
module scanout_decode
    import scanout_pkg::*;
(
    input  logic [SIZE_W-1:0] size_reg,
    input  logic              disp_enable,
    input  logic [1:0]        pix_format,
    input  logic              video_out,
    input  logic              interlace,
    input  logic              blank_req,
    output scan_geom_t        geom
);
    logic [WORD_FW-1:0] word_f;
    logic [LINE_FW-1:0] line_f;
    logic [MOD_FW-1:0]  mod_f;
    logic [WORD_FW:0]   words;
    logic [LINE_FW:0]   lines;
    logic [SUM_W-1:0]   pitch_words;
    pix_fmt_e           fmt;
    logic               on;

    always_comb begin
        word_f      = size_reg[WORD_FW-1:0];
        line_f      = size_reg[LINE_LSB +: LINE_FW];
        mod_f       = size_reg[MOD_LSB +: MOD_FW];
        words       = {1'b0, word_f} + 1'b1;
        lines       = {1'b0, line_f} + 1'b1;
        // words + (modulo) = (W+1) + (M-1) = W + M
        pitch_words = SUM_W'(word_f) + SUM_W'(mod_f);
        fmt         = pix_fmt_e'(pix_format);
        on          = disp_enable & video_out;

        geom.en     = on;
        geom.fmt    = fmt;
        geom.hres   = on ? pixels_per_line(fmt, words) : '0;
        geom.vres   = on ? field_lines(lines, interlace) : '0;
        geom.stride = {pitch_words, 2'b00};
        geom.blank  = blank_req;
    end
endmodule

// File: rtl/scanout_change_detect.sv
module scanout_change_detect
    import scanout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  scan_geom_t next_geom,
    input  scan_geom_t cur_geom,
    output logic       changed
);
    logic differs;

    always_comb begin
        differs = (next_geom.hres != cur_geom.hres) ||
                  (next_geom.vres != cur_geom.vres) ||
                  (next_geom.fmt  != cur_geom.fmt);
    end

    always_ff @(posedge clk) begin
        if (rst) changed <= 1'b0;
        else     changed <= strobe && next_geom.en && differs;
    end
endmodule

// File: rtl/scanout_line_walker.sv
module scanout_line_walker #(
    parameter int ADDR_W   = 24,
    parameter int STRIDE_W = 13,
    parameter int VRES_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                req,
    input  logic                en,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [VRES_W-1:0]   vres,
    output logic                vld,
    output logic [ADDR_W-1:0]   addr
);
    logic [ADDR_W-1:0] cursor;
    logic [VRES_W-1:0] issued;
    logic              take;

    always_comb begin
        take = req && !load && en && (issued < vres);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cursor <= '0;
            issued <= '0;
            addr   <= '0;
            vld    <= 1'b0;
        end else begin
            vld <= take;
            if (load) begin
                cursor <= load_addr;
                issued <= '0;
            end else if (take) begin
                addr   <= cursor;
                cursor <= cursor + ADDR_W'(stride);
                issued <= issued + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scanout_param_unit.sv
module scanout_param_unit
    import scanout_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                line_req,
    input  logic [SIZE_W-1:0]   size_reg,
    input  logic                disp_enable,
    input  logic [1:0]          pix_format,
    input  logic                video_out,
    input  logic                interlace,
    input  logic                blank_req,
    input  logic [BORDER_W-1:0] border_reg,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic                disp_en,
    output logic [1:0]          color_fmt,
    output logic [HRES_W-1:0]   hres,
    output logic [VRES_W-1:0]   vres,
    output logic [STRIDE_W-1:0] stride_bytes,
    output logic [ADDR_W-1:0]   start_addr,
    output logic                blank,
    output logic [BORDER_W-1:0] border_color,
    output logic                fmt_changed,
    output logic                line_vld,
    output logic [ADDR_W-1:0]   line_addr
);
    scan_geom_t          geom_next;
    scan_geom_t          geom_q;
    logic [ADDR_W-1:0]   start_q;
    logic [BORDER_W-1:0] border_q;

    scanout_decode u_decode (
        .size_reg    (size_reg),
        .disp_enable (disp_enable),
        .pix_format  (pix_format),
        .video_out   (video_out),
        .interlace   (interlace),
        .blank_req   (blank_req),
        .geom        (geom_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q   <= '0;
            start_q  <= '0;
            border_q <= '0;
        end else if (frame_start) begin
            geom_q   <= geom_next;
            start_q  <= base_addr;
            border_q <= border_reg;
        end
    end

    scanout_change_detect u_change (
        .clk       (clk),
        .rst       (rst),
        .strobe    (frame_start),
        .next_geom (geom_next),
        .cur_geom  (geom_q),
        .changed   (fmt_changed)
    );

    scanout_line_walker #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .VRES_W   (VRES_W)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_start),
        .load_addr (base_addr),
        .req       (line_req),
        .en        (geom_q.en),
        .stride    (geom_q.stride),
        .vres      (geom_q.vres),
        .vld       (line_vld),
        .addr      (line_addr)
    );

    always_comb begin
        disp_en      = geom_q.en;
        color_fmt    = geom_q.fmt;
        hres         = geom_q.hres;
        vres         = geom_q.vres;
        stride_bytes = geom_q.stride;
        blank        = geom_q.blank;
        start_addr   = start_q;
        border_color = border_q;
    end
endmodule

// File: rtl/scanout_param_checks.sv
module scanout_param_checks
    import scanout_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              disp_en,
    input logic [HRES_W-1:0] hres,
    input logic [VRES_W-1:0] vres,
    input logic [ADDR_W-1:0] start_addr,
    input logic              fmt_changed,
    input logic              line_vld
);
    assert_off_zero_res_R4: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> (hres == '0 && vres == '0));

    assert_vld_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        line_vld |-> disp_en);

    assert_chg_follows_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        fmt_changed |-> $past(frame_start));

    assert_hold_between_frames_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> ($stable(hres) && $stable(vres) && $stable(start_addr)));

    assert_no_line_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !line_vld);
endmodule

bind scanout_param_unit scanout_param_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .disp_en     (disp_en),
    .hres        (hres),
    .vres        (vres),
    .start_addr  (start_addr),
    .fmt_changed (fmt_changed),
    .line_vld    (line_vld)
);

// File: tb/scanout_param_unit_test.sv
module scanout_param_unit_test;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic          line_req = 1'b0;
    logic [29:0]   size_reg = '0;
    logic          disp_enable = 1'b0;
    logic [1:0]    pix_format = '0;
    logic          video_out = 1'b0;
    logic          interlace = 1'b0;
    logic          blank_req = 1'b0;
    logic [31:0]   border_reg = '0;
    logic [AW-1:0] base_addr = '0;

    logic          disp_en;
    logic [1:0]    color_fmt;
    logic [11:0]   hres;
    logic [11:0]   vres;
    logic [12:0]   stride_bytes;
    logic [AW-1:0] start_addr;
    logic          blank;
    logic [31:0]   border_color;
    logic          fmt_changed;
    logic          line_vld;
    logic [AW-1:0] line_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int prev_h = 0, prev_v = 0, prev_f = 0;

    always #5 clk = ~clk;

    scanout_param_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_req(line_req),
        .size_reg(size_reg), .disp_enable(disp_enable), .pix_format(pix_format),
        .video_out(video_out), .interlace(interlace), .blank_req(blank_req),
        .border_reg(border_reg), .base_addr(base_addr),
        .disp_en(disp_en), .color_fmt(color_fmt), .hres(hres), .vres(vres),
        .stride_bytes(stride_bytes), .start_addr(start_addr), .blank(blank),
        .border_color(border_color), .fmt_changed(fmt_changed),
        .line_vld(line_vld), .line_addr(line_addr)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [29:0] mk_size(input int wf, input int lf, input int mf);
        return {mf[9:0], lf[9:0], wf[9:0]};
    endfunction

    function automatic int exp_hres(input int f, input int words);
        if (f <= 1) return words * 2;
        if (f == 2) return (words * 4) / 3;
        return words;
    endfunction

    // Apply a configuration and strobe a frame; returns at the negedge after latching.
    task automatic frame(input logic [29:0] sz, input int f, input bit de, input bit vo,
                         input bit il, input bit bl, input logic [31:0] bd,
                         input logic [AW-1:0] base);
        @(negedge clk);
        size_reg = sz; pix_format = f[1:0]; disp_enable = de; video_out = vo;
        interlace = il; blank_req = bl; border_reg = bd; base_addr = base;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic request_line();
        @(negedge clk);
        line_req = 1'b1;
        @(negedge clk);
        line_req = 1'b0;
    endtask

    task automatic expect_change(input int h, input int v, input int f, input bit en);
        bit exp_chg;
        exp_chg = en && (h != prev_h || v != prev_v || f != prev_f);
        chk("R7 fmt_changed", fmt_changed, exp_chg);
        prev_h = h; prev_v = v; prev_f = f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 disp_en", disp_en, 0);
        chk("R10 hres", hres, 0);
        chk("R10 vres", vres, 0);
        chk("R10 stride", stride_bytes, 0);
        chk("R10 start_addr", start_addr, 0);
        chk("R10 line_vld", line_vld, 0);
        chk("R10 fmt_changed", fmt_changed, 0);

        // Sweep formats, word counts and interlace (R1, R2, R3, R7)
        for (int f = 0; f < 4; f++) begin
            for (int w = 1; w <= 9; w++) begin
                for (int il = 0; il < 2; il++) begin
                    int lf, mf, v;
                    lf = w + 2;
                    mf = (w * 7 + f) % 5;
                    frame(mk_size(w - 1, lf, mf), f, 1, 1, il[0], 0, 32'h0, 24'h001000);
                    v = il ? 2 * (lf + 1) : lf + 1;
                    chk("R2 hres", hres, exp_hres(f, w));
                    chk("R3 vres", vres, v);
                    chk("R1 stride", stride_bytes, ((w - 1 + mf) * 4) % 8192);
                    chk("R2 color_fmt", color_fmt, f);
                    chk("R4 disp_en", disp_en, 1);
                    expect_change(exp_hres(f, w), v, f, 1);
                    @(negedge clk);
                    chk("R7 pulse width", fmt_changed, 0);
                end
            end
        end

        // R1 large fields
        frame(mk_size(1023, 1023, 1023), 3, 1, 1, 1, 0, 32'h0, 24'h0);
        chk("R1 max stride", stride_bytes, ((1023 + 1023) * 4) % 8192);
        chk("R2 max hres", hres, 1024);
        chk("R3 max vres", vres, 2048);
        expect_change(1024, 2048, 3, 1);

        // R7: identical frame and pitch-only change give no pulse
        frame(mk_size(1023, 1023, 1023), 3, 1, 1, 1, 0, 32'h0, 24'h0);
        expect_change(1024, 2048, 3, 1);
        frame(mk_size(1023, 1023, 5), 3, 1, 1, 1, 1, 32'h5, 24'h40);
        expect_change(1024, 2048, 3, 1);
        chk("R1 pitch-only stride", stride_bytes, (1023 + 5) * 4);

        // R4: disabled via either bit
        frame(mk_size(10, 10, 1), 1, 0, 1, 0, 0, 32'h0, 24'h100);
        chk("R4 disp_enable off", disp_en, 0);
        chk("R4 hres zero", hres, 0);
        chk("R4 vres zero", vres, 0);
        chk("R4 no change pulse", fmt_changed, 0);
        prev_h = 0; prev_v = 0; prev_f = 1;
        request_line();
        chk("R4 no line when off", line_vld, 0);
        frame(mk_size(10, 10, 1), 1, 1, 0, 0, 0, 32'h0, 24'h100);
        chk("R4 video_out off", disp_en, 0);
        chk("R4 hres zero 2", hres, 0);
        // enabling again after disabled frame raises the flag
        frame(mk_size(10, 10, 1), 1, 1, 1, 0, 0, 32'h0, 24'h100);
        expect_change(22, 11, 1, 1);

        // R5: blanking and border
        frame(mk_size(3, 3, 1), 0, 1, 1, 0, 1, 32'hDEADBEEF, 24'h200);
        chk("R5 blank set", blank, 1);
        chk("R5 border", border_color, 32'hDEADBEEF);
        frame(mk_size(3, 3, 1), 0, 1, 1, 0, 0, 32'h00123456, 24'h200);
        chk("R5 blank clear", blank, 0);
        chk("R5 border 2", border_color, 32'h00123456);

        // R6: mid-frame register writes ignored
        @(negedge clk);
        size_reg = mk_size(50, 50, 50); pix_format = 2'd3; interlace = 1'b1;
        base_addr = 24'hABCDEF; blank_req = 1'b1; border_reg = 32'h1;
        repeat (4) @(negedge clk);
        chk("R6 hres held", hres, 8);
        chk("R6 vres held", vres, 4);
        chk("R6 start held", start_addr, 24'h200);
        chk("R6 blank held", blank, 0);
        chk("R6 border held", border_color, 32'h00123456);
        chk("R6 fmt held", color_fmt, 0);

        // R8/R9: line walk with address wrap past vres (interlaced, 3 lines -> 6)
        begin
            int sb;
            logic [AW-1:0] base;
            base = 24'hFFFFE0;
            frame(mk_size(3, 2, 2), 3, 1, 1, 1, 0, 32'h0, base);
            sb = (3 + 2) * 4;
            chk("R3 walk vres", vres, 6);
            chk("R8 start_addr", start_addr, base);
            for (int i = 0; i < 8; i++) begin
                request_line();
                chk("R9 line_vld", line_vld, (i < 6) ? 1 : 0);
                if (i < 6) chk("R8 line_addr", line_addr, (base + i * sb) % (1 << AW));
                @(negedge clk);
                chk("R8 strobe width", line_vld, 0);
            end
        end

        // R9: request coinciding with frame_start ignored, then restart at new base
        @(negedge clk);
        base_addr = 24'h000400; frame_start = 1'b1; line_req = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; line_req = 1'b0;
        chk("R9 req on strobe", line_vld, 0);
        request_line();
        chk("R8 restart vld", line_vld, 1);
        chk("R8 restart addr", line_addr, 24'h000400);
        request_line();
        chk("R8 second addr", line_addr, 24'h000400 + 20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule